// File: doc/BRIEF.md
# Shift-Add Nine-Tap Symmetric FIR Engine

This block filters a stream of signed samples with a fixed nine-tap FIR response whose coefficients mirror about the centre tap. No multipliers are used. Mirrored taps are summed first, each fractional coefficient is built from right shifts and one add or subtract, and shared partial results are computed once. The ten remaining operations are spread over four clock steps on three adders and one subtractor. Each unit writes its result to its own dedicated result register.

A producer presents a sample with `in_valid` while `in_ready` is high. The sample enters a nine-deep history, and the engine then runs its four steps. During those steps `in_ready` is low, and any strobe in that window is dropped. One cycle after the last step, `out_valid` pulses and `out_sample` carries the filtered value. The coefficients are 1/8, 1/4, -3/4 and 5/4 on the outer four mirrored pairs (outermost first), and 1 on the centre tap.

Top module: `fir9_shift_add`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_sample` is 0, and every history tap holds zero.
- R2: An accepted sample (`in_valid` and `in_ready` high at a rising edge) drops `in_ready` for exactly four cycles. The four steps run in the order 1, 2, 3, 4.
- R3: `in_valid` asserted while `in_ready` is low is ignored: the history does not shift, and later outputs match a stream without that sample.
- R4: `out_valid` is high for exactly one cycle, five rising edges after the accepting edge.
- R5: While `out_valid` is high, `out_sample` equals y = ((p08>>>3) + (d4 + (p17>>>2))) + ((p35 + (p35>>>2)) - (p26 - (p26>>>2))). Here di is the sample accepted i acceptances ago (d0 is the newest), and pij = di + dj. The result is an 11-bit two's-complement value.
- R6: Every right shift is arithmetic and rounds toward negative infinity. For example, a lone sample of -1 produces an output of -1.
- R7: Feeding an impulse of 64 into a cleared history, followed by zeros, gives the outputs 8, 16, -48, 80, 64, 80, -48, 16, 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 8 | Signed input sample |
| in_ready | output | 1 | High when a new sample can be taken |
| out_valid | output | 1 | One-cycle result strobe |
| out_sample | output | 11 | Signed filtered result |

## Verification
The assertions take for granted that `in_valid` and `in_sample` are driven to known values, and that strobes arriving during a computation may be present but carry no meaning. The stimulus drives inputs only on falling edges. Between fixed-seed random samples it sometimes raises `in_valid` with junk data in the busy window, which tests the drop rule. Directed runs at full positive and full negative scale bound the range that the three guard bits must absorb.

// File: rtl/fir9_pkg.sv
package fir9_pkg;
    parameter int SAMPLE_W = 8;
    parameter int GUARD_W  = 3;
    parameter int TAPS     = 9;
    localparam int ACC_W   = SAMPLE_W + GUARD_W;
    localparam int N_ADD   = 3;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_S1   = 3'd1,
        ST_S2   = 3'd2,
        ST_S3   = 3'd3,
        ST_S4   = 3'd4
    } step_e;

    typedef struct packed {
        acc_t r1;
        acc_t r2;
        acc_t r3;
        acc_t r4;
    } regs_t;

    typedef struct packed {
        logic w1;
        logic w2;
        logic w3;
        logic w4;
        acc_t v1;
        acc_t v2;
        acc_t v3;
        acc_t v4;
    } wr_t;

    function automatic acc_t asr(input acc_t x, input int unsigned n);
        return x >>> n;
    endfunction
endpackage

// File: rtl/fir9_history.sv
module fir9_history
    import fir9_pkg::*;
#(
    parameter int DEPTH = TAPS,
    parameter int W     = SAMPLE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps
);
    always_ff @(posedge clk) begin
        if (rst)        taps[0] <= '0;
        else if (shift) taps[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)        taps[i] <= '0;
            else if (shift) taps[i] <= taps[i-1];
        end
    end
endmodule

// File: rtl/fir9_step_ctrl.sv
module fir9_step_ctrl
    import fir9_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output step_e step,
    output logic  ready,
    output logic  done
);
    step_e nxt;

    always_comb begin
        unique case (step)
            ST_IDLE: nxt = start ? ST_S1 : ST_IDLE;
            ST_S1:   nxt = ST_S2;
            ST_S2:   nxt = ST_S3;
            ST_S3:   nxt = ST_S4;
            ST_S4:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_IDLE;
            done <= 1'b0;
        end else begin
            step <= nxt;
            done <= (step == ST_S4);
        end
    end

    assign ready = (step == ST_IDLE);

    // R2
    step_order_chk: assert property (@(posedge clk) disable iff (rst)
        (step == ST_S1) |=> (step == ST_S2));
endmodule

// File: rtl/fir9_alu_bank.sv
module fir9_alu_bank
    import fir9_pkg::*;
(
    input  step_e            step,
    input  acc_t [TAPS-1:0]  d,
    input  regs_t            r,
    output wr_t              wr
);
    acc_t [N_ADD-1:0] opa;
    acc_t [N_ADD-1:0] opb;
    acc_t [N_ADD-1:0] sum;
    acc_t             sub_a;
    acc_t             sub_b;
    acc_t             diff;

    always_comb begin
        opa   = '0;
        opb   = '0;
        sub_a = '0;
        sub_b = '0;
        unique case (step)
            ST_S1: begin
                opa[0] = d[1]; opb[0] = d[7];
                opa[1] = d[2]; opb[1] = d[6];
                opa[2] = d[3]; opb[2] = d[5];
            end
            ST_S2: begin
                opa[0] = d[0];  opb[0] = d[8];
                opa[1] = d[4];  opb[1] = asr(r.r1, 2);
                opa[2] = r.r3;  opb[2] = asr(r.r3, 2);
                sub_a  = r.r2;  sub_b  = asr(r.r2, 2);
            end
            ST_S3: begin
                opa[0] = asr(r.r1, 3); opb[0] = r.r2;
                sub_a  = r.r3;         sub_b  = r.r4;
            end
            ST_S4: begin
                opa[0] = r.r1; opb[0] = r.r4;
            end
            default: ;
        endcase
    end

    for (genvar k = 0; k < N_ADD; k++) begin : g_add
        assign sum[k] = opa[k] + opb[k];
    end
    assign diff = sub_a - sub_b;

    always_comb begin
        wr.v1 = sum[0];
        wr.v2 = sum[1];
        wr.v3 = sum[2];
        wr.v4 = diff;
        wr.w1 = (step != ST_IDLE);
        wr.w2 = (step == ST_S1) || (step == ST_S2);
        wr.w3 = (step == ST_S1) || (step == ST_S2);
        wr.w4 = (step == ST_S2) || (step == ST_S3);
    end
endmodule

// File: rtl/fir9_shift_add.sv
module fir9_shift_add
    import fir9_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                in_ready,
    output logic                out_valid,
    output logic [ACC_W-1:0]    out_sample
);
    logic                            accept;
    logic [TAPS-1:0][SAMPLE_W-1:0]   raw;
    acc_t [TAPS-1:0]                 dext;
    step_e                           step;
    regs_t                           r;
    wr_t                             wr;

    assign accept = in_valid && in_ready;

    fir9_history #(.DEPTH(TAPS), .W(SAMPLE_W)) u_hist (
        .clk(clk), .rst(rst), .shift(accept), .din(in_sample), .taps(raw)
    );

    for (genvar i = 0; i < TAPS; i++) begin : g_ext
        assign dext[i] = acc_t'($signed(raw[i]));
    end

    fir9_step_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(accept),
        .step(step), .ready(in_ready), .done(out_valid)
    );

    fir9_alu_bank u_alu (
        .step(step), .d(dext), .r(r), .wr(wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '0;
        end else begin
            if (wr.w1) r.r1 <= wr.v1;
            if (wr.w2) r.r2 <= wr.v2;
            if (wr.w3) r.r3 <= wr.v3;
            if (wr.w4) r.r4 <= wr.v4;
        end
    end

    assign out_sample = r.r1;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> $stable(raw));
    // R4
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R4
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept, 5));
endmodule

// File: tb/test_fir9_shift_add.sv
module test_fir9_shift_add;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_sample = '0;
    logic        in_ready;
    logic        out_valid;
    logic [10:0] out_sample;

    int n_chk = 0;
    int n_bad = 0;
    int hist [9];
    bit done_run = 0;

    always #5 clk = ~clk;

    fir9_shift_add i_fir9_shift_add (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model();
        int p17, p26, p35, p08, t2, t3, t4;
        p17 = hist[1] + hist[7];
        p26 = hist[2] + hist[6];
        p35 = hist[3] + hist[5];
        p08 = hist[0] + hist[8];
        t2 = hist[4] + (p17 >>> 2);
        t3 = p35 + (p35 >>> 2);
        t4 = p26 - (p26 >>> 2);
        return ((p08 >>> 3) + t2) + (t3 - t4);
    endfunction

    // Push one sample, optionally poke a junk strobe while busy, check result.
    task automatic push(input int x, input bit junk, input string req, input int want);
        int exp;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2", int'(in_ready), 1);
        in_valid  = 1'b1;
        in_sample = x[7:0];
        @(negedge clk);
        for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        exp = (want == 32'h7fffffff) ? model() : want;
        in_valid = junk;
        in_sample = junk ? 8'h5A : 8'h00;
        for (int c = 1; c <= 4; c++) begin
            chk(in_ready == 1'b0, "R2", int'(in_ready), 0);
            chk(out_valid == 1'b0, "R4", int'(out_valid), 0);
            if (c < 4) @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        chk(out_valid == 1'b1, "R4", int'(out_valid), 1);
        chk(int'($signed(out_sample)) == exp, req, int'($signed(out_sample)), exp);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4", int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog actual=hang expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int imp [9] = '{8, 16, -48, 80, 64, 80, -48, 16, 8};
        seed = $urandom(32'h1234_5A5A);
        foreach (hist[i]) hist[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_sample == '0, "R1", int'($signed(out_sample)), 0);

        // R6: lone -1 from cleared history gives -1 (floor shifts)
        push(-1, 1'b0, "R6", -1);
        // R1 history was cleared: second sample alone in model agrees
        push(0, 1'b0, "R1", 32'h7fffffff);

        // flush and R7 impulse
        for (int i = 0; i < 9; i++) push(0, 1'b0, "R5", 32'h7fffffff);
        push(64, 1'b0, "R7", imp[0]);
        for (int i = 1; i < 9; i++) push(0, 1'b0, "R7", imp[i]);

        // full-scale corners
        for (int i = 0; i < 10; i++) push(127, 1'b0, "R5", 32'h7fffffff);
        for (int i = 0; i < 10; i++) push(-128, 1'b0, "R5", 32'h7fffffff);
        for (int i = 0; i < 10; i++) push((i % 2) ? 127 : -128, 1'b0, "R5", 32'h7fffffff);

        // R3 junk strobes during busy, then random stream
        for (int i = 0; i < 6; i++) push(i * 9 - 20, 1'b1, "R3", 32'h7fffffff);
        for (int i = 0; i < 400; i++) begin
            int v;
            bit j;
            v = int'($signed(8'($urandom())));
            j = ($urandom() % 3) == 0;
            push(v, j, j ? "R3" : "R5", 32'h7fffffff);
        end

        done_run = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule